// File: doc/BRIEF.md
# Sound Generator Bus Write Sequencer

This block drives the three bus-control lines and the 8-bit shared address/data bus of a programmable sound generator. A host hands it one command at a time. There are three commands. A full register write first latches a register index and then writes a data byte. A data-only write sends a new byte to whichever register the sound chip last latched. A chip reset pulses the reset line and then waits out the chip's recovery time. Each bus phase lasts a minimum time given in nanoseconds. The block turns each of these times into a cycle count from the `CLK_HZ` parameter, so it can be reused at any clock rate.

The host uses a request/acknowledge handshake. A request is taken only while `busy` is low. `done` pulses in the last cycle of every sequence. A synchronous active-high system reset starts the chip-reset sequence on its own, so the sound chip is always reset before the first host command. Between commands the bus rests in the inactive code.

The three control lines form the code {reset_n, bdir, bc1}: 000 resets the chip, 100 is inactive, 110 writes data and 111 latches an address. The code 101 (read) is never driven.

Top module: `psg_bus_sequencer`

## Requirements
- R1: `bus_ctl` only ever carries 000 (chip reset), 100 (inactive), 110 (write data) or 111 (latch address), as {reset_n, bdir, bc1}; 101 is never driven.
- R2: Every phase lasts exactly ceil(t_ns * CLK_HZ / 1e9) cycles, and at least one cycle. At the default 125 MHz this gives setup 50 ns = 7, latch 400 ns = 50, gap 100 ns = 13, write 1800 ns = 225, reset pulse 500 ns = 63 and recovery 5000 ns = 625.
- R3: A full write (cmd 00) runs these phases in order: index on `bus_da` with code 100 (setup), code 111 (latch), code 100 (gap), data on `bus_da` with code 100 (setup), code 110 (write), code 100 (gap).
- R4: During a full write, code 110 never appears before code 111.
- R5: A data-only write (cmd 01) runs only data setup (100), write (110) and gap (100), with the data byte on `bus_da`, and never drives 111.
- R6: System reset `rst` drives 000 for the reset pulse and then 100 for the 5 µs recovery, with `busy` high and `ack` low throughout, and ends with a `done` pulse.
- R7: Host command 10 runs the same reset pulse and recovery from idle.
- R8: When not busy, `bus_ctl` is 100 and `busy` is low.
- R9: `ack` is high in exactly the cycles where `req` is high, `busy` is low and `cmd` is not 11; `busy` rises in the next cycle. A request held high while busy is taken in the first idle cycle.
- R10: `done` is high for one cycle, the last cycle of a sequence; in the next cycle `busy` is low.
- R11: Command 11 is ignored: there is no `ack`, `busy` stays low and the bus stays at 100.
- R12: `bus_da` stays constant throughout each phase, and the data byte is already on the bus the cycle before code 110 starts.
- R13: Raising `rst` in the middle of any sequence gives `bus_ctl` = 000 at the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the chip-reset sequence |
| req | input | 1 | Host request |
| cmd | input | 2 | Command: 00 full write, 01 data-only write, 10 chip reset, 11 reserved |
| reg_idx | input | DATA_W | Register index for a full write |
| wr_data | input | DATA_W | Data byte to write |
| ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse in the final cycle of a sequence |
| bus_ctl | output | 3 | Bus-control code {reset_n, bdir, bc1} |
| bus_da | output | DATA_W | Shared address/data bus to the sound generator |

## Verification
Two events can meet at a sequence boundary: the end of one sequence and the acceptance of the next request. The bench holds `req` high through the whole power-up reset. It then checks that `ack` stays low in the cycle where `done` is high, and that `ack` is given in the cycle right after, once `busy` has fallen. It also checks that the full write that follows has a correct trace. A second collision is a system reset arriving in the middle of a write phase. The bench checks that the reset code appears at the next cycle and that the recovery then runs for its full length.

// File: rtl/psg_seq_pkg.sv
package psg_seq_pkg;

  typedef enum logic [2:0] {
    CTL_RESET    = 3'b000,
    CTL_INACTIVE = 3'b100,
    CTL_READ     = 3'b101,
    CTL_WRITE    = 3'b110,
    CTL_LATCH    = 3'b111
  } bus_code_t;

  typedef enum logic [1:0] {
    CMD_FULL    = 2'b00,
    CMD_DATA    = 2'b01,
    CMD_CHIPRST = 2'b10,
    CMD_RSVD    = 2'b11
  } host_cmd_t;

  typedef enum logic [3:0] {
    PH_RST_LOW,
    PH_RST_WAIT,
    PH_IDLE,
    PH_ADDR_SETUP,
    PH_LATCH,
    PH_ADDR_GAP,
    PH_DATA_SETUP,
    PH_WRITE,
    PH_DATA_GAP
  } phase_t;

  // Minimum time in ns -> cycles, rounded up, never below one.
  function automatic int unsigned hold_cycles(input longint unsigned ns,
                                              input longint unsigned clk_hz);
    longint unsigned c;
    c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psg_hold_timer.sv
module psg_hold_timer #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned RESET_LOAD = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cycles,
  output logic             last
);

  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RESET_LOAD - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= RST_CNT;
    else if (load)         cnt <= load_cycles - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

  // R2: an unloaded counter steps down by exactly one per cycle
  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R2: a load never asks for a zero-length phase
  p_load_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_cycles != '0));

endmodule

// File: rtl/psg_phase_ctrl.sv
module psg_phase_ctrl
  import psg_seq_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned T_SETUP  = 7,
  parameter int unsigned T_LATCH  = 50,
  parameter int unsigned T_GAP    = 13,
  parameter int unsigned T_WRITE  = 225,
  parameter int unsigned T_RSTLOW = 63,
  parameter int unsigned T_RSTWT  = 625
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  host_cmd_t        start_cmd,
  input  logic             timer_last,
  output phase_t           phase,
  output logic             load,
  output logic [CNT_W-1:0] load_cycles,
  output logic             seq_end
);

  phase_t nxt;

  function automatic logic [CNT_W-1:0] phase_len(input phase_t p);
    case (p)
      PH_RST_LOW:    return CNT_W'(T_RSTLOW);
      PH_RST_WAIT:   return CNT_W'(T_RSTWT);
      PH_ADDR_SETUP: return CNT_W'(T_SETUP);
      PH_LATCH:      return CNT_W'(T_LATCH);
      PH_ADDR_GAP:   return CNT_W'(T_GAP);
      PH_DATA_SETUP: return CNT_W'(T_SETUP);
      PH_WRITE:      return CNT_W'(T_WRITE);
      PH_DATA_GAP:   return CNT_W'(T_GAP);
      default:       return CNT_W'(1);
    endcase
  endfunction

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          case (start_cmd)
            CMD_FULL:    nxt = PH_ADDR_SETUP;
            CMD_DATA:    nxt = PH_DATA_SETUP;
            CMD_CHIPRST: nxt = PH_RST_LOW;
            default:     nxt = PH_IDLE;
          endcase
        end
      end
      PH_RST_LOW:    if (timer_last) nxt = PH_RST_WAIT;
      PH_RST_WAIT:   if (timer_last) nxt = PH_IDLE;
      PH_ADDR_SETUP: if (timer_last) nxt = PH_LATCH;
      PH_LATCH:      if (timer_last) nxt = PH_ADDR_GAP;
      PH_ADDR_GAP:   if (timer_last) nxt = PH_DATA_SETUP;
      PH_DATA_SETUP: if (timer_last) nxt = PH_WRITE;
      PH_WRITE:      if (timer_last) nxt = PH_DATA_GAP;
      PH_DATA_GAP:   if (timer_last) nxt = PH_IDLE;
      default:       nxt = PH_IDLE;
    endcase
  end

  assign load        = (nxt != phase);
  assign load_cycles = phase_len(nxt);
  assign seq_end     = timer_last && ((phase == PH_DATA_GAP) || (phase == PH_RST_WAIT));

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_RST_LOW;
    else     phase <= nxt;
  end

  // R3: a timed phase is left only when its hold has run out
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !timer_last) |=> (phase == $past(phase)));

  // R3: the data setup of a full write follows the address gap
  p_gap_before_data_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_ADDR_GAP && phase != PH_ADDR_GAP) |-> (phase == PH_DATA_SETUP));

endmodule

// File: rtl/psg_bus_drive.sv
module psg_bus_drive
  import psg_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic              start,
  input  host_cmd_t         start_cmd,
  input  logic [DATA_W-1:0] reg_idx,
  input  logic [DATA_W-1:0] wr_data,
  output bus_code_t         bus_code,
  output logic [DATA_W-1:0] bus_val
);

  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] data_q;
  logic              addr_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      data_q <= '0;
    end else if (start && (start_cmd == CMD_FULL || start_cmd == CMD_DATA)) begin
      if (start_cmd == CMD_FULL) idx_q <= reg_idx;
      data_q <= wr_data;
    end
  end

  assign addr_phase = (phase == PH_ADDR_SETUP) || (phase == PH_LATCH) ||
                      (phase == PH_ADDR_GAP);
  assign bus_val    = addr_phase ? idx_q : data_q;

  always_comb begin
    case (phase)
      PH_RST_LOW: bus_code = CTL_RESET;
      PH_LATCH:   bus_code = CTL_LATCH;
      PH_WRITE:   bus_code = CTL_WRITE;
      default:    bus_code = CTL_INACTIVE;
    endcase
  end

endmodule

// File: rtl/psg_bus_sequencer.sv
module psg_bus_sequencer
  import psg_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned     DATA_W      = 8,
  parameter int unsigned     SETUP_NS    = 50,
  parameter int unsigned     LATCH_NS    = 400,
  parameter int unsigned     GAP_NS      = 100,
  parameter int unsigned     WRITE_NS    = 1800,
  parameter int unsigned     RST_LOW_NS  = 500,
  parameter int unsigned     RST_WAIT_NS = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        cmd,
  input  logic [DATA_W-1:0] reg_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ack,
  output logic              busy,
  output logic              done,
  output logic [2:0]        bus_ctl,
  output logic [DATA_W-1:0] bus_da
);

  localparam int unsigned T_SETUP  = hold_cycles(SETUP_NS, CLK_HZ);
  localparam int unsigned T_LATCH  = hold_cycles(LATCH_NS, CLK_HZ);
  localparam int unsigned T_GAP    = hold_cycles(GAP_NS, CLK_HZ);
  localparam int unsigned T_WRITE  = hold_cycles(WRITE_NS, CLK_HZ);
  localparam int unsigned T_RSTLOW = hold_cycles(RST_LOW_NS, CLK_HZ);
  localparam int unsigned T_RSTWT  = hold_cycles(RST_WAIT_NS, CLK_HZ);
  localparam int unsigned T_MAX    = max2(max2(max2(T_SETUP, T_LATCH), max2(T_GAP, T_WRITE)),
                                          max2(T_RSTLOW, T_RSTWT));
  localparam int unsigned CNT_W    = $clog2(T_MAX + 1);

  host_cmd_t        host_cmd;
  phase_t           phase;
  bus_code_t        bus_code;
  logic             timer_last;
  logic             timer_load;
  logic [CNT_W-1:0] timer_cycles;
  logic             seq_end;
  logic             is_idle;

  assign host_cmd = host_cmd_t'(cmd);
  assign is_idle  = (phase == PH_IDLE);
  assign ack      = req && is_idle && (host_cmd != CMD_RSVD);
  assign busy     = !is_idle;
  assign done     = seq_end;
  assign bus_ctl  = bus_code;

  psg_hold_timer #(
    .CNT_W      (CNT_W),
    .RESET_LOAD (T_RSTLOW)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .load        (timer_load),
    .load_cycles (timer_cycles),
    .last        (timer_last)
  );

  psg_phase_ctrl #(
    .CNT_W    (CNT_W),
    .T_SETUP  (T_SETUP),
    .T_LATCH  (T_LATCH),
    .T_GAP    (T_GAP),
    .T_WRITE  (T_WRITE),
    .T_RSTLOW (T_RSTLOW),
    .T_RSTWT  (T_RSTWT)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (ack),
    .start_cmd   (host_cmd),
    .timer_last  (timer_last),
    .phase       (phase),
    .load        (timer_load),
    .load_cycles (timer_cycles),
    .seq_end     (seq_end)
  );

  psg_bus_drive #(
    .DATA_W (DATA_W)
  ) u_drive (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .start     (ack),
    .start_cmd (host_cmd),
    .reg_idx   (reg_idx),
    .wr_data   (wr_data),
    .bus_code  (bus_code),
    .bus_val   (bus_da)
  );

  // Named bus events for the checks below
  logic in_write;
  logic in_latch;
  assign in_write = (bus_ctl == CTL_WRITE);
  assign in_latch = (bus_ctl == CTL_LATCH);

  // Assertion-only bookkeeping: which command is open, and whether its latch has happened
  logic full_open;
  logic latch_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      full_open  <= 1'b0;
      latch_seen <= 1'b0;
    end else if (ack) begin
      full_open  <= (host_cmd == CMD_FULL);
      latch_seen <= 1'b0;
    end else if (in_latch) begin
      latch_seen <= 1'b1;
    end
  end

  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_ctl == 3'b000 || bus_ctl == 3'b100 || bus_ctl == 3'b110 || bus_ctl == 3'b111));

  p_latch_before_write_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_write) && full_open) |-> latch_seen);

  p_no_latch_outside_full_r5: assert property (@(posedge clk) disable iff (rst)
    in_latch |-> full_open);

  p_idle_inactive_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bus_ctl == CTL_INACTIVE));

  p_ack_only_idle_r9: assert property (@(posedge clk) disable iff (rst)
    ack |-> !busy);

  p_busy_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  p_reserved_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (req && cmd == 2'b11) |-> !ack);

  p_data_stable_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(in_write) |-> $stable(bus_da));

  p_reset_code_r13: assert property (@(posedge clk)
    rst |=> (bus_ctl == CTL_RESET));

endmodule

// File: tb/test_psg_bus_sequencer.sv
module test_psg_bus_sequencer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [7:0] reg_idx = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       ack, busy, done;
  logic [2:0] bus_ctl;
  logic [7:0] bus_da;

  always #4 clk = ~clk;  // 125 MHz

  psg_bus_sequencer i_psg_bus_sequencer (
    .clk(clk), .rst(rst), .req(req), .cmd(cmd), .reg_idx(reg_idx),
    .wr_data(wr_data), .ack(ack), .busy(busy), .done(done),
    .bus_ctl(bus_ctl), .bus_da(bus_da)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Expected cycle count at an 8 ns period (R2), restated independently
  function automatic int cyc8(input int ns);
    int c;
    c = ns / 8;
    if (c * 8 < ns) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Trace capture: run-length segments of (code, bus value)
  logic [2:0] seg_code [8];
  logic [7:0] seg_da   [8];
  int         seg_len  [8];
  int         nseg;
  int         ack_seen;
  int         timed_out;

  logic [2:0] e_code [8];
  logic [7:0] e_da   [8];
  int         e_len  [8];
  int         e_n;

  task automatic capture();
    int cyc;
    cyc = 0; nseg = 0; ack_seen = 0; timed_out = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (ack) ack_seen++;
      if (nseg == 0 || bus_ctl != seg_code[nseg-1] || bus_da != seg_da[nseg-1]) begin
        if (nseg < 8) begin
          seg_code[nseg] = bus_ctl; seg_da[nseg] = bus_da; seg_len[nseg] = 1; nseg++;
        end
      end else begin
        seg_len[nseg-1]++;
      end
      if (done) break;
      if (cyc > 4000) begin timed_out = 1; break; end
    end
  endtask

  task automatic expect_full(input logic [7:0] idx, input logic [7:0] dat);
    e_n = 6;
    e_code[0] = 3'b100; e_da[0] = idx; e_len[0] = cyc8(50);
    e_code[1] = 3'b111; e_da[1] = idx; e_len[1] = cyc8(400);
    e_code[2] = 3'b100; e_da[2] = idx; e_len[2] = cyc8(100);
    e_code[3] = 3'b100; e_da[3] = dat; e_len[3] = cyc8(50);
    e_code[4] = 3'b110; e_da[4] = dat; e_len[4] = cyc8(1800);
    e_code[5] = 3'b100; e_da[5] = dat; e_len[5] = cyc8(100);
  endtask

  task automatic expect_data(input logic [7:0] dat);
    e_n = 3;
    e_code[0] = 3'b100; e_da[0] = dat; e_len[0] = cyc8(50);
    e_code[1] = 3'b110; e_da[1] = dat; e_len[1] = cyc8(1800);
    e_code[2] = 3'b100; e_da[2] = dat; e_len[2] = cyc8(100);
  endtask

  task automatic compare_trace(input string tag);
    check({tag, " done reached"}, timed_out, 0);
    check({tag, " segment count"}, nseg, e_n);
    for (int i = 0; i < e_n && i < nseg; i++) begin
      check($sformatf("%s R1 R3 code seg%0d", tag, i), int'(seg_code[i]), int'(e_code[i]));
      check($sformatf("%s R12 bus value seg%0d", tag, i), int'(seg_da[i]), int'(e_da[i]));
      check($sformatf("%s R2 length seg%0d", tag, i), seg_len[i], e_len[i]);
    end
    check({tag, " R9 no ack while busy"}, ack_seen, 0);
  endtask

  task automatic after_done(input string tag);
    @(negedge clk);
    check({tag, " R10 busy low after done"}, int'(busy), 0);
    check({tag, " R10 done single cycle"}, int'(done), 0);
    check({tag, " R8 idle code"}, int'(bus_ctl), 3'b100);
  endtask

  task automatic issue(input logic [1:0] c, input logic [7:0] idx, input logic [7:0] dat);
    @(negedge clk);
    req = 1'b1; cmd = c; reg_idx = idx; wr_data = dat;
    #1;
    check("R9 ack on idle request", int'(ack), 1);
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  // Stimulus table: {cmd, index, data}
  localparam logic [17:0] VEC [6] = '{
    {2'b00, 8'd7,  8'h38},
    {2'b00, 8'd10, 8'h0C},
    {2'b00, 8'd5,  8'h00},
    {2'b00, 8'd4,  8'h51},
    {2'b01, 8'd0,  8'h3C},
    {2'b01, 8'd0,  8'h51}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // Reset state, with a full-write request held through the whole reset (R6, R9)
    req = 1'b1; cmd = 2'b00; reg_idx = 8'h03; wr_data = 8'hAA;
    repeat (4) @(negedge clk);
    check("R6 reset code during rst", int'(bus_ctl), 3'b000);
    check("R6 busy during rst", int'(busy), 1);
    check("R6 no ack during rst", int'(ack), 0);
    rst = 1'b0;
    capture();
    check("R6 done reached", timed_out, 0);
    check("R6 segment count", nseg, 2);
    check("R6 R1 pulse code", int'(seg_code[0]), 3'b000);
    check("R6 R2 pulse length", seg_len[0] + 1, cyc8(500));
    check("R6 R1 recovery code", int'(seg_code[1]), 3'b100);
    check("R6 R2 recovery length", seg_len[1], cyc8(5000));
    check("R6 R9 no ack during reset", ack_seen, 0);
    // Held request taken in the first idle cycle after done (R9)
    @(negedge clk);
    check("R9 busy low after reset", int'(busy), 0);
    check("R9 held request acked", int'(ack), 1);
    @(posedge clk);
    #1 req = 1'b0;
    capture();
    expect_full(8'h03, 8'hAA);
    compare_trace("R9 held request");
    after_done("R9");

    // Table walk: full writes to mixer/amplitude/period registers, then data-only writes
    for (int i = 0; i < 6; i++) begin
      issue(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
      capture();
      if (VEC[i][17:16] == 2'b00) begin
        expect_full(VEC[i][15:8], VEC[i][7:0]);
        compare_trace($sformatf("R3 R4 vec%0d", i));
      end else begin
        expect_data(VEC[i][7:0]);
        compare_trace($sformatf("R5 vec%0d", i));
      end
      after_done($sformatf("vec%0d", i));
    end

    // A request made while busy is ignored and the trace is unchanged (R9)
    issue(2'b01, 8'h00, 8'h99);
    fork
      capture();
      begin
        repeat (20) @(negedge clk);
        #2 req = 1'b1; cmd = 2'b00; reg_idx = 8'h09; wr_data = 8'h11;
        repeat (5) @(negedge clk);
        #2 req = 1'b0;
      end
    join
    expect_data(8'h99);
    compare_trace("R9 busy request");
    after_done("R9 busy");

    // Reserved command ignored (R11)
    @(negedge clk);
    req = 1'b1; cmd = 2'b11; reg_idx = 8'h01; wr_data = 8'h22;
    #1;
    check("R11 no ack on reserved", int'(ack), 0);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (busy || ack || bus_ctl != 3'b100 || bus_da != 8'h99) bad++;
      end
      check("R11 bus and busy untouched", bad, 0);
    end
    req = 1'b0;

    // Host chip-reset command (R7)
    issue(2'b10, 8'h00, 8'h00);
    capture();
    e_n = 2;
    e_code[0] = 3'b000; e_da[0] = 8'h99; e_len[0] = cyc8(500);
    e_code[1] = 3'b100; e_da[1] = 8'h99; e_len[1] = cyc8(5000);
    compare_trace("R7 host reset");
    after_done("R7");

    // System reset in the middle of the write phase (R13)
    issue(2'b00, 8'h06, 8'h5A);
    repeat (100) @(negedge clk);
    check("R13 in write phase before rst", int'(bus_ctl), 3'b110);
    rst = 1'b1;
    @(negedge clk);
    check("R13 reset code next cycle", int'(bus_ctl), 3'b000);
    check("R13 busy during rst", int'(busy), 1);
    rst = 1'b0;
    capture();
    check("R13 recovery done", timed_out, 0);
    check("R13 segment count", nseg, 2);
    check("R13 R2 pulse length", seg_len[0] + 1, cyc8(500));
    check("R13 R2 recovery length", seg_len[1], cyc8(5000));
    after_done("R13");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule